// File: doc/BRIEF.md
# Keyed Analog-Test Switch Configuration Register

A single 32-bit configuration register guarded per write. Each bus write carries an 8-bit key in its top byte. The payload is stored only when that key equals 0x5A. A write with any other key is discarded and leaves the stored value as it was. The key is never held, so reads always return zero in the key byte.

The stored payload drives nine control outputs. One is a supply select. The other eight are switch controls that close or open isolation and grounding switches in an analog test path. Software unlocks and updates the register in one access. To protect the value afterwards, software writes it with a wrong key, which has no effect on the contents.

A single-cycle accept pulse reports, for every write, whether the key matched.

Top module: `keyed_cfg_reg`

## Requirements
- R1: Synchronous active-high reset clears the payload. After reset every switch output is 0 (open), the supply select is 0, and a read returns 0x00000000.
- R2: A write whose bits [31:24] equal 0x5A stores bits [8:0] of the written word. The new value appears at the outputs and in read data from the cycle after the write.
- R3: A write whose bits [31:24] differ from 0x5A leaves the payload, the outputs and the read data unchanged.
- R4: Read data bits [31:24] are always 0x00, whatever key was last written.
- R5: Read data bits [23:9] are always zero, and writes to those bits have no effect.
- R6: Bit [8] drives the supply select output (1 selects the primary supply, 0 the secondary). Bits [7:0] drive the eight switch outputs `sw_close_o[7:0]` in the same bit order, where 1 means closed.
- R7: `wr_accept_o` is high for exactly the one cycle after a write with a matching key. It is low after a rejected write and low in cycles with no write.
- R8: Read data is combinational from the stored payload and is valid in the same cycle as `rd_en_i`. When `rd_en_i` is low, read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| wr_data_i | input | 32 | Write word: key in [31:24], payload in [8:0] |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read word: payload in [8:0], all other bits zero |
| wr_accept_o | output | 1 | One-cycle pulse after a write whose key matched |
| supply_sel_o | output | 1 | Supply select: 1 primary, 0 secondary |
| sw_close_o | output | 8 | Switch controls, 1 closes a switch |

## Verification
A wrong stored payload appears at the switch outputs and in read data on the cycle after the faulty write, so every write is followed by a port comparison before the next one. A key check that is too loose or too strict also shows up in the accept pulse on that same cycle. Leakage of key bits or unused bits into storage would show up as nonzero upper read bits on the next read. Random words with about half the writes carrying the correct key exercise both paths, and directed keys that differ from 0x5A by a single bit test the comparator at its edges.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned KEY_W    = 8;
    localparam int unsigned KEY_LSB  = WORD_W - KEY_W;
    localparam int unsigned SW_N     = 8;
    localparam int unsigned PAY_W    = SW_N + 1;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'h5A;

    typedef struct packed {
        logic            supply_sel;
        logic [SW_N-1:0] sw_close;
    } cfg_payload_t;

    function automatic logic key_matches(input logic [WORD_W-1:0] word);
        return word[WORD_W-1:KEY_LSB] == UNLOCK_KEY;
    endfunction

    function automatic cfg_payload_t extract_payload(input logic [WORD_W-1:0] word);
        return cfg_payload_t'(word[PAY_W-1:0]);
    endfunction

    function automatic logic [WORD_W-1:0] pack_readback(input cfg_payload_t p);
        return {{(WORD_W-PAY_W){1'b0}}, p};
    endfunction
endpackage

// File: rtl/keyed_cfg_gate.sv
module keyed_cfg_gate
    import keyed_cfg_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              commit_o,
    output cfg_payload_t      next_o
);
    always_comb begin
        commit_o = wr_en_i && key_matches(wr_data_i);
        next_o   = extract_payload(wr_data_i);
    end
endmodule

// File: rtl/keyed_cfg_store.sv
module keyed_cfg_store
    import keyed_cfg_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         commit_i,
    input  cfg_payload_t next_i,
    output cfg_payload_t cur_o,
    output logic         accept_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_o    <= '0;
            accept_o <= 1'b0;
        end else begin
            accept_o <= commit_i;
            if (commit_i) cur_o <= next_i;
        end
    end

    a_r3_hold_on_reject: assert property (@(posedge clk_i) disable iff (rst_i)
        !commit_i |=> $stable(cur_o));
    a_r7_pulse_follows_commit: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_i |=> accept_o);
endmodule

// File: rtl/keyed_cfg_reg.sv
module keyed_cfg_reg
    import keyed_cfg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              wr_accept_o,
    output logic              supply_sel_o,
    output logic [SW_N-1:0]   sw_close_o
);
    logic         commit;
    cfg_payload_t next_val;
    cfg_payload_t cur_val;

    keyed_cfg_gate u_gate (
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .commit_o (commit),
        .next_o   (next_val)
    );

    keyed_cfg_store u_store (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .commit_i(commit),
        .next_i  (next_val),
        .cur_o   (cur_val),
        .accept_o(wr_accept_o)
    );

    always_comb begin
        supply_sel_o = cur_val.supply_sel;
        sw_close_o   = cur_val.sw_close;
        rd_data_o    = rd_en_i ? pack_readback(cur_val) : '0;
    end

    a_r4_key_reads_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_data_o[WORD_W-1:KEY_LSB] == '0);
    a_r5_unused_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_data_o[KEY_LSB-1:PAY_W] == '0);
    a_r2_accept_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_data_i[WORD_W-1:KEY_LSB] == UNLOCK_KEY) |=>
        ({supply_sel_o, sw_close_o} == $past(wr_data_i[PAY_W-1:0])));
    a_r7_no_pulse_without_key: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && wr_data_i[WORD_W-1:KEY_LSB] == UNLOCK_KEY) |=> !wr_accept_o);
    a_r6_outputs_match_read: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i |-> rd_data_o[PAY_W-1:0] == {supply_sel_o, sw_close_o});
endmodule

// File: tb/test_keyed_cfg_reg.sv
module test_keyed_cfg_reg;
    logic        clk = 0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        acc, sup;
    logic [7:0]  sw;
    int checks = 0, errors = 0;
    logic [8:0]  model;

    always #2 clk = ~clk;

    keyed_cfg_reg i_keyed_cfg_reg (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .wr_accept_o(acc),
        .supply_sel_o(sup), .sw_close_o(sw)
    );

    function automatic logic exp_accept(input logic [31:0] w);
        return w[31:24] == 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // drive a write, then check outputs mid-cycle after the edge
    task automatic do_write(input logic [31:0] w);
        logic a;
        a = exp_accept(w);
        wr_en = 1; wr_data = w;
        @(posedge clk); #1;
        wr_en = 0; wr_data = 0;
        if (a) model = w[8:0];
        chk(a ? "R7 accept" : "R7 reject", {31'b0, acc}, {31'b0, a});
        chk(a ? "R2 load" : "R3 hold", {23'b0, sup, sw}, {23'b0, model});
        chk("R6 supply bit8", {31'b0, sup}, {31'b0, model[8]});
        rd_en = 1; #0.5;
        chk("R4 R5 R8 readback", rd_data, {23'b0, model});
        rd_en = 0; #0.5;
        chk("R8 read idle zero", rd_data, 32'h0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd1234));
        rst = 1; wr_en = 0; rd_en = 0; wr_data = 0; model = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        rd_en = 1; #0.5;
        chk("R1 reset read", rd_data, 32'h0);
        chk("R1 reset outputs", {23'b0, sup, sw}, 32'h0);
        rd_en = 0; #0.5;
        chk("R7 idle no pulse", {31'b0, acc}, 32'h0);
        // directed cases
        do_write(32'h5A00_01FF);               // all closed, primary supply
        do_write(32'h5B00_0000);               // one-bit key miss
        do_write(32'hDA00_0000);               // top-bit key miss
        do_write(32'h0000_0000);               // zero key
        do_write(32'h5AFF_FE55);               // R5 unused bits set
        do_write(32'h5A00_0100);               // only supply select
        do_write(32'h5A00_0000);               // all open
        do_write(32'hFFFF_FFFF);               // rejected, all ones
        @(posedge clk); #1;
        chk("R7 no pulse after idle", {31'b0, acc}, 32'h0);
        // random mix
        for (int i = 0; i < 300; i++) begin
            w = $urandom;
            if ($urandom % 2) w[31:24] = 8'h5A;
            do_write(w);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule